// File: doc/BRIEF.md
# Raster-Position Start-of-Frame Pulse Generator

This block follows the raster position of a clocked video stream and marks the start of each frame with a one-cycle pulse. It keeps three position counters that advance only on beats where `vid_valid` is high. The subsample index alternates 0/1 across a line, which matches the Cb/Y/Cr/Y ordering of 4:2:2 data. The sample index restarts at each rising edge of horizontal sync. The line index restarts at each rising edge of vertical sync.

Two placement modes are available. In coordinate mode the pulse fires on the beat whose (subsample, sample, line) position equals a programmed triple. This lets the frame start be moved away from the raster origin, for example to line up with a reference source. In sync mode the pulse fires on the beat where vertical sync rises. When the stream is interlaced, both modes suppress the pulse during the second field.

The programmed triple is captured only at a frame boundary, so a write made in the middle of a frame cannot produce a stray pulse. The default counter widths cover a raster of 858 samples by 525 lines.

Top module: `sof_locator`

## Requirements
- R1: After reset, `sof_o` is low and stays low until a beat qualifies under R4, R6 or R7.
- R2: `sof_o` is high for exactly one clock cycle. It is high in the cycle that follows the qualifying beat.
- R3: A valid beat with `hsync` high, where the previous valid beat had `hsync` low, is at sample 0 and subsample 0. Each later valid beat adds 1 to the sample index and inverts the subsample index. The line index increments on each such `hsync` rise, except when `vsync` rises on the same valid beat; then the line index is 0.
- R4: With `sync_mode`=0 (coordinate mode), a pulse follows each valid beat whose (subsample, sample, line) position equals (`cfg_sub`, `cfg_sample`, `cfg_line`). The setting (0,0,0) pulses on the beat where `vsync` rises.
- R5: In coordinate mode, off-origin settings such as (1,1,1) and (1,7,3) pulse at that position. A setting whose subsample does not match the parity of its sample, such as (0,7,3), never pulses.
- R6: With `sync_mode`=1 (sync mode), a pulse follows each valid beat where `vsync` rises, and the coordinate inputs have no effect.
- R7: When `interlaced`=1 and `field`=1 on the qualifying beat, no pulse is produced in either mode. With `field`=0, pulses occur as in R4 and R6.
- R8: The coordinate inputs are captured on the valid beat where `vsync` rises, and that beat already uses the new values. Changes made later in the frame take effect only from the next frame.
- R9: Beats with `vid_valid`=0 are ignored. They produce no pulse, do not move the counters, and their sync levels are not used for edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| vid_valid | input | 1 | Beat qualifier: high on cycles that carry a pixel |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| field | input | 1 | Field bit: 0 = first field, 1 = second field |
| interlaced | input | 1 | High when the stream is interlaced |
| sync_mode | input | 1 | 0 = coordinate mode, 1 = sync mode |
| cfg_sub | input | 1 | Programmed subsample index |
| cfg_sample | input | SAMPLE_W | Programmed sample index |
| cfg_line | input | LINE_W | Programmed line index |
| sof_o | output | 1 | Start-of-frame pulse, one cycle wide |

## Verification
The hardest case to reach is a change of the programmed triple in the middle of a frame. The new value must stay invisible until the next vertical sync rise, so the bench moves the coordinates to a position that lies later in the same frame and expects no pulse there. A second hard case is a sync edge that occurs while `vid_valid` is low. To reach it, the driver inserts idle cycles at random with random sync and field levels, so edges and matching positions fall both on idle cycles and on valid beats. Interlaced suppression is reached by alternating the field bit frame by frame in both modes.

// File: rtl/sof_locator_pkg.sv
package sof_locator_pkg;
  localparam int unsigned DEF_SAMPLE_W = 11;
  localparam int unsigned DEF_LINE_W   = 11;
  localparam int unsigned MIN_SAMPLES  = 858;
  localparam int unsigned MIN_LINES    = 525;

  typedef enum logic {
    MODE_COORD = 1'b0,
    MODE_VSYNC = 1'b1
  } sof_mode_e;
endpackage

// File: rtl/sof_rst_sync.sv
module sof_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/sof_raster_count.sv
module sof_raster_count #(
  parameter int unsigned SAMPLE_W = 11,
  parameter int unsigned LINE_W   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                vid_valid,
  input  logic                hsync,
  input  logic                vsync,
  output logic                h_edge,
  output logic                v_edge,
  output logic                cur_sub,
  output logic [SAMPLE_W-1:0] cur_sample,
  output logic [LINE_W-1:0]   cur_line
);
  localparam logic [SAMPLE_W-1:0] SAMPLE_MAX = {SAMPLE_W{1'b1}};
  localparam logic [LINE_W-1:0]   LINE_MAX   = {LINE_W{1'b1}};

  logic                hs_q, vs_q, sub_q;
  logic [SAMPLE_W-1:0] samp_q;
  logic [LINE_W-1:0]   line_q;

  logic                hs_n, vs_n, sub_n;
  logic [SAMPLE_W-1:0] samp_n;
  logic [LINE_W-1:0]   line_n;

  // position of the present beat
  always_comb begin
    h_edge     = vid_valid & hsync & ~hs_q;
    v_edge     = vid_valid & vsync & ~vs_q;
    cur_sub    = h_edge ? 1'b0 : sub_q;
    cur_sample = h_edge ? '0 : samp_q;
    if (v_edge)
      cur_line = '0;
    else if (h_edge && line_q != LINE_MAX)
      cur_line = line_q + 1'b1;
    else
      cur_line = line_q;
  end

  // next state, advanced only on valid beats
  always_comb begin
    hs_n   = hs_q;
    vs_n   = vs_q;
    sub_n  = sub_q;
    samp_n = samp_q;
    line_n = line_q;
    if (vid_valid) begin
      hs_n   = hsync;
      vs_n   = vsync;
      sub_n  = ~cur_sub;
      samp_n = (cur_sample == SAMPLE_MAX) ? cur_sample : cur_sample + 1'b1;
      line_n = cur_line;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      sub_q  <= 1'b0;
      samp_q <= '0;
      line_q <= '0;
    end else begin
      hs_q   <= hs_n;
      vs_q   <= vs_n;
      sub_q  <= sub_n;
      samp_q <= samp_n;
      line_q <= line_n;
    end
  end

  // R9: idle cycles leave the raster state untouched
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_valid |=> ($stable(samp_q) && $stable(line_q) && $stable(sub_q) && $stable(hs_q)));

  // R3: a line start puts the following beat at sample 1, subsample 1
  a_r3_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_valid && hsync && !hs_q) |=> (samp_q == 1 && sub_q == 1'b1));
endmodule

// File: rtl/sof_coord_shadow.sv
module sof_coord_shadow #(
  parameter int unsigned SAMPLE_W = 11,
  parameter int unsigned LINE_W   = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                cfg_sub,
  input  logic [SAMPLE_W-1:0] cfg_sample,
  input  logic [LINE_W-1:0]   cfg_line,
  output logic                eff_sub,
  output logic [SAMPLE_W-1:0] eff_sample,
  output logic [LINE_W-1:0]   eff_line
);
  logic                sub_q, sub_n;
  logic [SAMPLE_W-1:0] samp_q, samp_n;
  logic [LINE_W-1:0]   line_q, line_n;

  always_comb begin
    sub_n  = load ? cfg_sub    : sub_q;
    samp_n = load ? cfg_sample : samp_q;
    line_n = load ? cfg_line   : line_q;
    // the boundary beat already compares against the new setting
    eff_sub    = sub_n;
    eff_sample = samp_n;
    eff_line   = line_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= 1'b0;
      samp_q <= '0;
      line_q <= '0;
    end else begin
      sub_q  <= sub_n;
      samp_q <= samp_n;
      line_q <= line_n;
    end
  end

  // R8: the captured coordinates move only at a frame boundary
  a_r8_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(samp_q) && $stable(line_q) && $stable(sub_q)));
endmodule

// File: rtl/sof_pulse_gen.sv
module sof_pulse_gen #(
  parameter int unsigned SAMPLE_W = 11,
  parameter int unsigned LINE_W   = 11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vid_valid,
  input  logic                      v_edge,
  input  sof_locator_pkg::sof_mode_e mode,
  input  logic                      interlaced,
  input  logic                      field,
  input  logic                      cur_sub,
  input  logic [SAMPLE_W-1:0]       cur_sample,
  input  logic [LINE_W-1:0]         cur_line,
  input  logic                      eff_sub,
  input  logic [SAMPLE_W-1:0]       eff_sample,
  input  logic [LINE_W-1:0]         eff_line,
  output logic                      sof_o
);
  import sof_locator_pkg::*;

  logic hit, second_field, sof_n, sof_q;

  always_comb begin
    second_field = interlaced & field;
    unique case (mode)
      MODE_VSYNC: hit = v_edge;
      default:    hit = (cur_sub == eff_sub) && (cur_sample == eff_sample)
                        && (cur_line == eff_line);
    endcase
    sof_n = vid_valid & hit & ~second_field;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sof_q <= 1'b0;
    else        sof_q <= sof_n;
  end

  assign sof_o = sof_q;

  // R2: never two pulse cycles in a row
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q);

  // R7: no pulse for a second-field beat of an interlaced stream
  a_r7_no_second_field: assert property (@(posedge clk) disable iff (!rst_n)
    (interlaced && field) |=> !sof_q);

  // R9: a pulse always follows a valid beat
  a_r9_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_valid |=> !sof_q);
endmodule

// File: rtl/sof_locator.sv
module sof_locator
  import sof_locator_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned LINE_W   = DEF_LINE_W
) (
  input  logic                clk,
  input  logic                rst_ni,
  input  logic                vid_valid,
  input  logic                hsync,
  input  logic                vsync,
  input  logic                field,
  input  logic                interlaced,
  input  logic                sync_mode,
  input  logic                cfg_sub,
  input  logic [SAMPLE_W-1:0] cfg_sample,
  input  logic [LINE_W-1:0]   cfg_line,
  output logic                sof_o
);
  localparam bit WIDE_ENOUGH = ((64'd1 << SAMPLE_W) >= MIN_SAMPLES)
                             && ((64'd1 << LINE_W) >= MIN_LINES);

  logic                rst_n;
  logic                h_edge, v_edge;
  logic                cur_sub, eff_sub;
  logic [SAMPLE_W-1:0] cur_sample, eff_sample;
  logic [LINE_W-1:0]   cur_line, eff_line;
  sof_mode_e           mode;

  assign mode = sof_mode_e'(sync_mode);

  sof_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  sof_raster_count #(.SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid),
    .hsync(hsync), .vsync(vsync),
    .h_edge(h_edge), .v_edge(v_edge),
    .cur_sub(cur_sub), .cur_sample(cur_sample), .cur_line(cur_line)
  );

  sof_coord_shadow #(.SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(v_edge),
    .cfg_sub(cfg_sub), .cfg_sample(cfg_sample), .cfg_line(cfg_line),
    .eff_sub(eff_sub), .eff_sample(eff_sample), .eff_line(eff_line)
  );

  sof_pulse_gen #(.SAMPLE_W(SAMPLE_W), .LINE_W(LINE_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .vid_valid(vid_valid), .v_edge(v_edge),
    .mode(mode), .interlaced(interlaced), .field(field),
    .cur_sub(cur_sub), .cur_sample(cur_sample), .cur_line(cur_line),
    .eff_sub(eff_sub), .eff_sample(eff_sample), .eff_line(eff_line),
    .sof_o(sof_o)
  );

  // R3: a raster of 858 samples by 525 lines must fit the counters
  initial a_r3_width: assert (WIDE_ENOUGH);

  // R6: in sync mode a pulse always follows a vertical sync rise
  a_r6_vsync_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && v_edge && !(interlaced && field)) |=> sof_o);

  // unused in the top beyond the counters' own checks
  logic unused_h;
  assign unused_h = h_edge;
endmodule

// File: tb/tb_sof_locator.sv
module tb_sof_locator;
  localparam int SW = 11;
  localparam int LW = 11;
  localparam int SPL = 24;   // samples per line in the bench raster
  localparam int LPF = 8;    // lines per frame in the bench raster

  logic clk = 1'b0;
  logic rst_ni, vid_valid, hsync, vsync, field, interlaced, sync_mode, cfg_sub;
  logic [SW-1:0] cfg_sample;
  logic [LW-1:0] cfg_line;
  logic sof_o;

  sof_locator #(.SAMPLE_W(SW), .LINE_W(LW)) dut (
    .clk(clk), .rst_ni(rst_ni), .vid_valid(vid_valid), .hsync(hsync),
    .vsync(vsync), .field(field), .interlaced(interlaced),
    .sync_mode(sync_mode), .cfg_sub(cfg_sub), .cfg_sample(cfg_sample),
    .cfg_line(cfg_line), .sof_o(sof_o)
  );

  always #4 clk = ~clk;   // 125 MHz

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int unsigned exp_cyc[$];
  string       exp_req[$];
  string       phase_req = "R1";
  bit          mon_on = 1'b0;
  bit          gaps = 1'b0;

  // model of the captured coordinates
  bit          m_sub;
  int          m_samp, m_line;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // monitor: pop expected pulses and compare cycle stamps
  always @(negedge clk) begin
    if (mon_on && sof_o) begin
      if (exp_cyc.size() == 0) begin
        check(1'b0, phase_req, "unexpected pulse at cycle", int'(cyc), -1);
      end else begin
        int unsigned e;
        string r;
        e = exp_cyc.pop_front();
        r = exp_req.pop_front();
        check(e == cyc, r, "pulse cycle", int'(cyc), int'(e));
      end
    end
  end

  task automatic idle_cycle();
    vid_valid = 1'b0;
    hsync = 1'($urandom);
    vsync = 1'($urandom);
    field = 1'($urandom);
    @(negedge clk);
  endtask

  // driver: one frame; chg_line >= 0 moves the coordinates mid-frame
  task automatic drive_frame(input bit fld, input int chg_line,
                             input bit n_sub, input int n_samp, input int n_line);
    for (int l = 0; l < LPF; l++) begin
      for (int s = 0; s < SPL; s++) begin
        bit hit;
        while (gaps && ($urandom % 4 == 0)) idle_cycle();
        if (l == chg_line && s == 0) begin
          cfg_sub = n_sub; cfg_sample = SW'(n_samp); cfg_line = LW'(n_line);
        end
        vid_valid = 1'b1;
        hsync = (s < 2);
        vsync = (l < 2);
        field = fld;
        if (l == 0 && s == 0) begin
          m_sub = cfg_sub; m_samp = int'(cfg_sample); m_line = int'(cfg_line);
        end
        if (sync_mode) hit = (l == 0 && s == 0);
        else hit = (m_sub == bit'(s % 2)) && (m_samp == s) && (m_line == l);
        if (hit && !(interlaced && fld)) begin
          exp_cyc.push_back(cyc + 1);
          exp_req.push_back(phase_req);
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic end_phase();
    vid_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(exp_cyc.size() == 0, phase_req, "missed pulses", exp_cyc.size(), 0);
    exp_cyc.delete();
    exp_req.delete();
  endtask

  task automatic set_cfg(input bit s, input int sm, input int ln);
    cfg_sub = s; cfg_sample = SW'(sm); cfg_line = LW'(ln);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; vid_valid = 1'b0; hsync = 1'b0; vsync = 1'b0;
    field = 1'b0; interlaced = 1'b0; sync_mode = 1'b0;
    set_cfg(0, 0, 0);
    repeat (3) @(negedge clk);
    // R1: output low during reset
    check(sof_o == 1'b0, "R1", "sof_o in reset", sof_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(sof_o == 1'b0, "R1", "sof_o after reset", sof_o, 0);
    mon_on = 1'b1;

    // R4, R2, R3: origin setting, progressive
    phase_req = "R4"; set_cfg(0, 0, 0);
    repeat (2) drive_frame(0, -1, 0, 0, 0);
    end_phase();

    // R5: off-origin settings
    phase_req = "R5"; set_cfg(1, 1, 1);
    repeat (2) drive_frame(0, -1, 0, 0, 0);
    end_phase();
    set_cfg(1, 7, 3);
    repeat (2) drive_frame(0, -1, 0, 0, 0);
    end_phase();
    // R5: subsample parity mismatch never pulses
    set_cfg(0, 7, 3);
    repeat (2) drive_frame(0, -1, 0, 0, 0);
    end_phase();

    // R3: last sample of a later line
    phase_req = "R3"; set_cfg(1, SPL - 1, LPF - 1);
    repeat (2) drive_frame(0, -1, 0, 0, 0);
    end_phase();

    // R6: sync mode ignores coordinates
    phase_req = "R6"; sync_mode = 1'b1; set_cfg(1, 5, 4);
    repeat (3) drive_frame(0, -1, 0, 0, 0);
    end_phase();

    // R7: interlaced, alternate fields, both modes
    phase_req = "R7"; interlaced = 1'b1;
    for (int f = 0; f < 4; f++) drive_frame(bit'(f % 2), -1, 0, 0, 0);
    end_phase();
    sync_mode = 1'b0; set_cfg(1, 3, 2);
    for (int f = 0; f < 4; f++) drive_frame(bit'(f % 2), -1, 0, 0, 0);
    end_phase();
    interlaced = 1'b0;

    // R8: mid-frame change to a position later in the same frame
    phase_req = "R8"; set_cfg(1, 1, 1);
    drive_frame(0, 2, 1, 9, 5);
    drive_frame(0, -1, 0, 0, 0);
    end_phase();

    // R9: random idle cycles with random sync levels, both modes
    phase_req = "R9"; gaps = 1'b1; set_cfg(1, 11, 6);
    repeat (3) drive_frame(0, -1, 0, 0, 0);
    end_phase();
    sync_mode = 1'b1;
    repeat (3) drive_frame(0, -1, 0, 0, 0);
    end_phase();
    gaps = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule